// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach the management registers of external PHY devices over the two-wire MDIO/MDC serial bus, using Clause 22 frames. Software sees six word registers on a simple synchronous write port with a combinational read port. It selects the MDC rate, loads the target PHY and register address, and then starts a transfer. A read starts when the read value is written to the command register. A write starts when the 16-bit write data is written to the control register. Software then polls the busy register until the transfer has finished.

MDC is derived from the system clock. A 3-bit select field picks the divisor from a fixed, non-linear table. The serialiser changes MDIO on each falling MDC edge and samples it on each rising edge. During the turnaround and data bits of a read, the serialiser releases the line so the PHY can drive it. A reset bit in the configuration register holds the transfer engine and the MDC generator in reset without losing the configuration.

Top module: `mdio_master`

## Requirements
- R1: MDC stays low when no transfer is active. During a transfer, each high phase and each low phase of MDC lasts D/2 system clocks. D is taken from the 3-bit select field cfg[2:0] through the table 0→4, 1→4, 2→6, 3→8, 4→10, 5→14, 6→20, 7→28.
- R2: Register offset 0 holds the divisor select in bits [2:0] and a soft-reset bit in bit 31. While bit 31 is set, a running transfer is aborted, busy reads 0, MDC stays low, the output enable stays low and no new transfer can start. Writing the same select with bit 31 clear resumes normal operation.
- R3: Offset 2 holds the PHY address in bits [15:8] and the register address in bits [7:0]. The frame uses only the low 5 bits of each field, sent MSB first.
- R4: Writing 1 to the command register (offset 1) while idle starts a read frame. The frame is 32 ones, start bits 01, opcode 10, the PHY address and the register address. The master then releases MDIO (output enable low) for the 2 turnaround bits and the 16 data bits.
- R5: Writing the control register (offset 3) while idle starts a write frame. The frame is 32 ones, 01, opcode 01, the PHY address, the register address, turnaround 10 and data bits [15:0] MSB first. The output enable stays high for all 64 bits.
- R6: MDIO and its output enable change only on a falling MDC edge while a frame runs. The input is sampled on the rising MDC edge, so data that a PHY drives after each falling edge is captured correctly.
- R7: Bit 0 of the busy register (offset 5) reads 1 from the clock edge that accepts a start until the last falling MDC edge of the frame. It reads 0 at all other times.
- R8: After a read completes, the status register (offset 4) returns the received 16 bits in bits [15:0], with the upper bits zero.
- R9: A read command does not restart on its own. The command value stays readable, and no further frame begins until software writes again.
- R10: A write to the command or control register that arrives while busy is ignored. No frame is queued and the register contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
On every cycle, the assertions check these properties: MDC stays low and the output enable stays off whenever the engine is idle, MDIO changes only on a falling MDC edge during a frame, the soft reset stops MDC and busy on the next cycle, and a frame that ends never restarts without a register write. The bench scenarios check the remaining behaviour. A PHY model records each rising-edge bit and answers reads, which lets the bench check the frame contents, the divisor-table phase lengths, the received data in the status register, and that writes made while busy are discarded.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int SEL_W   = 3;
  localparam int MAX_DIV = 28;
  localparam int HALF_W  = $clog2(MAX_DIV / 2 + 1);

  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_CMD  = 3'd1,
    REG_ADDR = 3'd2,
    REG_CTRL = 3'd3,
    REG_STAT = 3'd4,
    REG_BUSY = 3'd5
  } reg_sel_e;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  // half of the MDC divisor, in system clocks
  function automatic logic [HALF_W-1:0] half_div(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0, 3'd1: half_div = HALF_W'(2);
      3'd2:       half_div = HALF_W'(3);
      3'd3:       half_div = HALF_W'(4);
      3'd4:       half_div = HALF_W'(5);
      3'd5:       half_div = HALF_W'(7);
      3'd6:       half_div = HALF_W'(10);
      default:    half_div = HALF_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half;
  logic              mdc_q;
  logic              tick;

  assign half   = half_div(sel_i);
  assign tick   = run_i && !srst_i && (cnt_q >= half - HALF_W'(1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (srst_i || !run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              start_i,
  input  logic              start_rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int FRAME_LEN = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DATA_POS  = FRAME_LEN - DATA_W;
  localparam int TA_POS    = DATA_POS - 2;

  logic [FRAME_LEN-1:0] sh_q;
  logic [FRAME_LEN-1:0] frame;
  logic [IDX_W-1:0]     idx_q;
  logic                 run_q;
  logic                 rd_q;
  logic [DATA_W-1:0]    in_q;
  logic [DATA_W-1:0]    rdata_q;

  assign frame = {{PRE_LEN{1'b1}}, 2'b01, (start_rd_i ? OP_RD : OP_WR), phy_i, reg_i,
                  (start_rd_i ? 2'b11 : 2'b10),
                  (start_rd_i ? {DATA_W{1'b1}} : wdata_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '1;
      idx_q   <= '0;
      run_q   <= 1'b0;
      rd_q    <= 1'b0;
      in_q    <= '0;
      rdata_q <= '0;
    end else if (srst_i) begin
      sh_q  <= '1;
      idx_q <= '0;
      run_q <= 1'b0;
      rd_q  <= 1'b0;
    end else if (!run_q) begin
      if (start_i) begin
        sh_q  <= frame;
        idx_q <= '0;
        run_q <= 1'b1;
        rd_q  <= start_rd_i;
      end
    end else begin
      if (rise_i && rd_q && (idx_q >= IDX_W'(DATA_POS)))
        in_q <= {in_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
          run_q <= 1'b0;
          if (rd_q) rdata_q <= in_q;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end

  assign busy_o  = run_q;
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign oe_o    = run_q && !(rd_q && (idx_q >= IDX_W'(TA_POS)));
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [SEL_W-1:0]  cfg_sel_q;
  logic              cfg_srst_q;
  logic              cmd_q;
  logic [15:0]       addr_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_data;
  logic              busy;
  logic              rise, fall;
  logic              wr_cfg, wr_cmd, wr_addr, wr_ctrl;
  logic              start, start_rd;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[30:16];

  assign wr_cfg  = wr_en_i && (addr_i == REG_CFG);
  assign wr_addr = wr_en_i && (addr_i == REG_ADDR);
  // command/control writes are dropped while a frame runs or soft reset is held
  assign wr_cmd  = wr_en_i && (addr_i == REG_CMD)  && !busy && !cfg_srst_q;
  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL) && !busy && !cfg_srst_q;

  assign start_rd = wr_cmd && wdata_i[0];
  assign start    = start_rd || wr_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_sel_q  <= '0;
      cfg_srst_q <= 1'b0;
      cmd_q      <= 1'b0;
      addr_q     <= '0;
      ctrl_q     <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_sel_q  <= wdata_i[SEL_W-1:0];
        cfg_srst_q <= wdata_i[31];
      end
      if (wr_cmd)  cmd_q  <= wdata_i[0];
      if (wr_addr) addr_q <= wdata_i[15:0];
      if (wr_ctrl) ctrl_q <= wdata_i[DATA_W-1:0];
    end
  end

  mdio_clk_gen u_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (cfg_srst_q),
    .run_i  (busy),
    .sel_i  (cfg_sel_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng #(
    .PRE_LEN (PRE_LEN),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_frame_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (cfg_srst_q),
    .start_i    (start),
    .start_rd_i (start_rd),
    .phy_i      (addr_q[8 +: ADDR_W]),
    .reg_i      (addr_q[0 +: ADDR_W]),
    .wdata_i    (wdata_i[DATA_W-1:0]),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdio_i     (mdio_i),
    .busy_o     (busy),
    .mdio_o     (mdio_o),
    .oe_o       (mdio_oe_o),
    .rdata_o    (stat_data)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CFG:  rdata_o = {cfg_srst_q, {(31-SEL_W){1'b0}}, cfg_sel_q};
      REG_CMD:  rdata_o = {31'b0, cmd_q};
      REG_ADDR: rdata_o = {16'b0, addr_q};
      REG_CTRL: rdata_o = 32'(ctrl_q);
      REG_STAT: rdata_o = 32'(stat_data);
      REG_BUSY: rdata_o = {31'b0, busy};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic srst_i,
  input logic wr_en_i,
  input logic mdc_i,
  input logic mdio_o_i,
  input logic oe_i
);
  assert_mdc_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i);

  assert_srst_halts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!busy_i && !mdc_i && !oe_i));

  assert_oe_only_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> busy_i);

  assert_drive_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !$stable({mdio_o_i, oe_i})) |-> $fell(mdc_i));

  assert_no_retrigger_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && !wr_en_i) |=> !busy_i);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy),
  .srst_i   (cfg_srst_q),
  .wr_en_i  (wr_en_i),
  .mdc_i    (mdc_o),
  .mdio_o_i (mdio_o),
  .oe_i     (mdio_oe_o)
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_in, mdio_out, mdio_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mdio_master dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .mdc_o     (mdc),
    .mdio_i    (mdio_in),
    .mdio_o    (mdio_out),
    .mdio_oe_o (mdio_oe)
  );

  // PHY model
  int          rise_cnt = 0;
  logic [63:0] rec_vec, oe_vec;
  logic        rd_mode = 1'b0;
  logic [15:0] resp_w = '0;
  realtime     t_rise = 0, t_fall = 0, hi_ns = 0, lo_ns = 0;

  initial mdio_in = 1'b1;

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      rec_vec[63-rise_cnt] = mdio_out;
      oe_vec[63-rise_cnt]  = mdio_oe;
    end
    rise_cnt = rise_cnt + 1;
    lo_ns  = $realtime - t_fall;
    t_rise = $realtime;
  end

  always @(negedge mdc) begin
    hi_ns  = $realtime - t_rise;
    t_fall = $realtime;
    if (rd_mode && rise_cnt >= 48 && rise_cnt < 64) mdio_in = resp_w[63-rise_cnt];
    else mdio_in = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] b;
    for (int i = 0; i < 5000; i++) begin
      bus_rd(3'd5, b);
      if (b[0] == 1'b0) break;
    end
  endtask

  function automatic int half_of(input int sel);
    case (sel)
      0, 1: return 2;
      2: return 3;
      3: return 4;
      4: return 5;
      5: return 7;
      6: return 10;
      default: return 14;
    endcase
  endfunction

  task automatic check_frame(input bit is_rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] data, input int sel);
    string tg;
    tg = is_rd ? "R4" : "R5";
    chk(rise_cnt == 64, {tg, " bit count"}, 64'(rise_cnt), 64);
    chk(rec_vec[63:32] == 32'hFFFF_FFFF, {tg, " preamble"}, 64'(rec_vec[63:32]), 64'hFFFF_FFFF);
    chk(rec_vec[31:30] == 2'b01, {tg, " start"}, 64'(rec_vec[31:30]), 1);
    chk(rec_vec[29:28] == (is_rd ? 2'b10 : 2'b01), {tg, " opcode"}, 64'(rec_vec[29:28]), is_rd ? 2 : 1);
    chk(rec_vec[27:23] == phy, "R3 phy address", 64'(rec_vec[27:23]), 64'(phy));
    chk(rec_vec[22:18] == rg, "R3 reg address", 64'(rec_vec[22:18]), 64'(rg));
    if (is_rd) begin
      chk(oe_vec == {{46{1'b1}}, 18'b0}, "R4 output enable release", oe_vec, {{46{1'b1}}, 18'b0});
    end else begin
      chk(rec_vec[17:16] == 2'b10, "R5 turnaround", 64'(rec_vec[17:16]), 2);
      chk(rec_vec[15:0] == data, "R5 write data", 64'(rec_vec[15:0]), 64'(data));
      chk(oe_vec == '1, "R5 output enable", oe_vec, '1);
    end
    chk(hi_ns == half_of(sel) * 20.0, "R1 high phase", 64'(int'(hi_ns)), 64'(half_of(sel) * 20));
    chk(lo_ns == half_of(sel) * 20.0, "R1 low phase", 64'(int'(lo_ns)), 64'(half_of(sel) * 20));
    chk(!mdc, "R1 mdc idle low", 64'(mdc), 0);
  endtask

  task automatic do_write(input int sel, input logic [7:0] phy, input logic [7:0] rg, input logic [15:0] d);
    logic [31:0] b;
    bus_wr(3'd0, 32'(sel));
    bus_wr(3'd2, {16'b0, phy, rg});
    rd_mode = 1'b0;
    rise_cnt = 0;
    bus_wr(3'd3, {16'b0, d});
    bus_rd(3'd5, b);
    chk(b == 1, "R7 busy after start", 64'(b), 1);
    wait_idle();
    bus_rd(3'd5, b);
    chk(b == 0, "R7 busy cleared", 64'(b), 0);
    check_frame(1'b0, phy[4:0], rg[4:0], d, sel);
  endtask

  task automatic do_read(input int sel, input logic [7:0] phy, input logic [7:0] rg,
                         input logic [15:0] resp, input bit clear_cmd);
    logic [31:0] b;
    bus_wr(3'd0, 32'(sel));
    bus_wr(3'd1, 0);
    bus_wr(3'd2, {16'b0, phy, rg});
    rd_mode = 1'b1;
    resp_w = resp;
    rise_cnt = 0;
    bus_wr(3'd1, 1);
    bus_rd(3'd5, b);
    chk(b == 1, "R7 busy after read start", 64'(b), 1);
    wait_idle();
    check_frame(1'b1, phy[4:0], rg[4:0], resp, sel);
    bus_rd(3'd4, b);
    chk(b == {16'b0, resp}, "R8 R6 status read data", 64'(b), 64'(resp));
    if (clear_cmd) bus_wr(3'd1, 0);
    rd_mode = 1'b0;
  endtask

  task automatic test_reset();
    logic [31:0] b;
    for (int a = 0; a < 6; a++) begin
      bus_rd(3'(a), b);
      chk(b == 0, "R7 reset register value", 64'(b), 0);
    end
    chk(!mdc && !mdio_oe, "R1 idle outputs after reset", {62'b0, mdc, mdio_oe}, 0);
  endtask

  task automatic test_no_retrigger();
    logic [31:0] b;
    do_read(3, 8'h05, 8'h02, 16'h0F0F, 1'b0);
    repeat (300) @(negedge clk);
    chk(rise_cnt == 64, "R9 no extra frame", 64'(rise_cnt), 64);
    bus_rd(3'd5, b);
    chk(b == 0, "R9 idle after read", 64'(b), 0);
    bus_rd(3'd1, b);
    chk(b == 1, "R9 command value kept", 64'(b), 1);
    bus_wr(3'd1, 0);
    repeat (50) @(negedge clk);
    chk(rise_cnt == 64, "R9 idle write starts nothing", 64'(rise_cnt), 64);
  endtask

  task automatic test_busy_ignore();
    logic [31:0] b;
    bus_wr(3'd0, 0);
    bus_wr(3'd1, 0);
    bus_wr(3'd2, 32'h0000_0304);
    rd_mode = 1'b0;
    rise_cnt = 0;
    bus_wr(3'd3, 32'h1234);
    repeat (20) @(negedge clk);
    bus_wr(3'd3, 32'hBEEF);
    bus_wr(3'd1, 1);
    wait_idle();
    chk(rec_vec[15:0] == 16'h1234, "R10 frame data kept", 64'(rec_vec[15:0]), 64'h1234);
    bus_rd(3'd3, b);
    chk(b == 32'h1234, "R10 control unchanged", 64'(b), 64'h1234);
    bus_rd(3'd1, b);
    chk(b == 0, "R10 command unchanged", 64'(b), 0);
    repeat (40) @(negedge clk);
    chk(rise_cnt == 64, "R10 nothing queued", 64'(rise_cnt), 64);
  endtask

  task automatic test_srst();
    logic [31:0] b;
    int r0;
    bus_wr(3'd0, 2);
    bus_wr(3'd2, 32'h0000_0101);
    rise_cnt = 0;
    bus_wr(3'd3, 32'hAAAA);
    repeat (60) @(negedge clk);
    bus_wr(3'd0, 32'h8000_0002);
    repeat (2) @(negedge clk);
    bus_rd(3'd5, b);
    chk(b == 0, "R2 busy cleared by soft reset", 64'(b), 0);
    chk(!mdc && !mdio_oe, "R2 mdc and oe low", {62'b0, mdc, mdio_oe}, 0);
    r0 = rise_cnt;
    bus_wr(3'd3, 32'h5555);
    repeat (60) @(negedge clk);
    chk(rise_cnt == r0, "R2 held during soft reset", 64'(rise_cnt), 64'(r0));
    bus_rd(3'd0, b);
    chk(b == 32'h8000_0002, "R2 config readback", 64'(b), 64'h8000_0002);
    bus_wr(3'd0, 2);
    do_write(2, 8'h01, 8'h01, 16'h5A5A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    do_write(0, 8'hE3, 8'h1F, 16'hC35A);
    do_write(7, 8'h11, 8'h00, 16'h8001);
    do_write(5, 8'h00, 8'hAA, 16'hFFFF);
    do_read(2, 8'h1A, 8'h09, 16'hBEEF, 1'b1);
    do_read(1, 8'hFF, 8'h13, 16'h0001, 1'b1);
    do_read(6, 8'h02, 8'h04, 16'h8000, 1'b1);
    do_write(4, 8'h07, 8'h1C, 16'h0000);
    test_no_retrigger();
    test_busy_ignore();
    test_srst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule